// File: doc/BRIEF.md
# Serial Test Port for Microcode ROM Readout

This block lets an external tester read an on-chip microcode ROM through a few slow pins. A pad test-enable pin puts the pads into test mode. In that mode each link output pin drives the inverse of its link input pin, which gives the tester a quick way to confirm that test mode is active. A second enable opens the ROM path. An address then enters serially, one bit per rising edge of a slow test shift clock. A low pulse on an active-low load strobe copies the addressed ROM word into an output shift register. The word then leaves on a serial output, one bit per rising edge of the same test clock.

All test pins are asynchronous to the core clock `clk`. They pass through a synchronizer `SYNC_STAGES` flops deep. The logic then acts on edges of the synchronized levels. A three-state machine controls the datapath:
- **ADDR** shifts the address.
- **LOAD** has captured a word and waits for the strobe to be released.
- **DATA** shifts the word out.

The transitions are:
- *load-capture*: ADDR or DATA goes to LOAD on a strobe fall while the shift clock is low.
- *strobe-release*: LOAD goes to DATA.
- *word-done*: DATA goes back to ADDR after `DATA_W` rising clock edges.

When either enable is low, the machine and all of its registers are frozen. The ROM is a synthesizable computed table.

Top module: `rom_test_port`

## Requirements
- R1: `link_out[i]` equals `~link_in[i]` whenever `pad_test_en` is high, and equals `core_link_out[i]` when it is low. This path is combinational.
- R2: The ROM path is active only while both `pad_test_en` and `rom_test_en` are high after synchronization. If either is low, `test_sclk`, `test_sdi` and `load_n` have no effect. In that case the state, the address register, the data register and `test_sdo` all hold.
- R3: In ADDR, each rising edge of `test_sclk` shifts in one address bit from `test_sdi`. The address is sent LSB first, so after `ADDR_W` edges the first bit sent is address bit 0.
- R4: A falling edge of `load_n` while `test_sclk` is low copies ROM[address] into the data register (load-capture). `test_sdo` then shows data bit 0 before any further clock edge. Releasing `load_n` moves the machine from LOAD to DATA (strobe-release).
- R5: A falling edge of `load_n` while `test_sclk` is high is ignored, and the data register keeps its value.
- R6: In DATA, each rising edge of `test_sclk` shifts the data register right by one bit, filling with zero, so `test_sdo` shows bits 1, 2, … in turn. The `DATA_W`-th edge returns the machine to ADDR (word-done), and `test_sdo` then reads 0.
- R7: The address register changes only on clock edges in ADDR. A new load, made from DATA in the middle of a read or from ADDR without shifting, therefore returns the same word again.
- R8: The ROM contents are defined as follows:
  - Address 0 holds all ones.
  - The all-ones address holds a word whose bit i equals i mod 2.
  - Every other address a holds ((a·37 + 11) XOR (a << DATA_W/2)) mod 2^DATA_W.
- R9: After reset the machine is in ADDR, the address and data registers are zero, and `test_sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock used to sample the test pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_test_en | input | 1 | Pad test mode enable |
| rom_test_en | input | 1 | ROM readout path enable |
| test_sclk | input | 1 | Slow test shift clock (sampled) |
| test_sdi | input | 1 | Serial address input |
| load_n | input | 1 | Active-low ROM-to-register load strobe |
| test_sdo | output | 1 | Serial data output (data register bit 0) |
| link_in | input | LINKS | Link input pins |
| core_link_out | input | LINKS | Normal-mode link output values |
| link_out | output | LINKS | Link output pins |

## Verification
The bench builds the block with `ADDR_W=4`, `DATA_W=8` and `SYNC_STAGES=2`. This makes the whole 16-word ROM readable, including both special addresses, and allows all 16 link input patterns to be swept in both pad modes. With such short words it is cheap to reload in the middle of a read, to freeze the port part way through a word and then resume, and to land a strobe while the shift clock is high. Every one of these results can be predicted from the ROM formula alone.

// File: rtl/rtp_pkg.sv
package rtp_pkg;
    typedef enum logic [1:0] {
        ST_ADDR = 2'd0,
        ST_LOAD = 2'd1,
        ST_DATA = 2'd2
    } rtp_state_e;
endpackage

// File: rtl/rtp_sync.sv
module rtp_sync #(
    parameter int WIDTH = 1,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[0] <= RESET_VAL;
                else        stage_q[0] <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= {STAGES{RESET_VAL}};
                else        stage_q <= {stage_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/rtp_rom.sv
module rtp_rom #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] word
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    logic [31:0] mix;

    always_comb begin
        mix = (32'(addr) * 32'd37 + 32'd11) ^ (32'(addr) << (DATA_W / 2));
        if (addr == '0) begin
            word = '1;
        end else if (addr == TOP_ADDR) begin
            for (int i = 0; i < DATA_W; i++) word[i] = 1'(i % 2);
        end else begin
            word = mix[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/rtp_loopback.sv
module rtp_loopback #(
    parameter int LINKS = 4
) (
    input  logic             pad_test_en,
    input  logic [LINKS-1:0] link_in,
    input  logic [LINKS-1:0] core_link_out,
    output logic [LINKS-1:0] link_out
);
    generate
        for (genvar g = 0; g < LINKS; g++) begin : g_lane
            assign link_out[g] = pad_test_en ? ~link_in[g] : core_link_out[g];
        end
    endgenerate
endmodule

// File: rtl/rom_test_port.sv
module rom_test_port
    import rtp_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int LINKS       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pad_test_en,
    input  logic             rom_test_en,
    input  logic             test_sclk,
    input  logic             test_sdi,
    input  logic             load_n,
    output logic             test_sdo,
    input  logic [LINKS-1:0] link_in,
    input  logic [LINKS-1:0] core_link_out,
    output logic [LINKS-1:0] link_out
);
    localparam int                NPINS = 5;
    localparam int                CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(DATA_W - 1);
    // pin order: pad_en, rom_en, sclk, sdi, load_n (load_n idles high)
    localparam logic [NPINS-1:0]  PIN_RST = 5'b00001;

    logic [NPINS-1:0]  pins_raw, pins_s;
    logic              pad_s, rom_s, sclk_s, sdi_s, ld_s;
    logic              sclk_prev, ld_prev;
    logic              test_on, clk_rise, ld_fall, load_fire;
    rtp_state_e        st_q, st_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [DATA_W-1:0] data_q, data_d, rom_word;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    assign pins_raw = {pad_test_en, rom_test_en, test_sclk, test_sdi, load_n};

    rtp_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES), .RESET_VAL(PIN_RST)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pins_raw),
        .q    (pins_s)
    );

    assign {pad_s, rom_s, sclk_s, sdi_s, ld_s} = pins_s;

    rtp_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom (
        .addr(addr_q),
        .word(rom_word)
    );

    rtp_loopback #(.LINKS(LINKS)) u_loop (
        .pad_test_en  (pad_test_en),
        .link_in      (link_in),
        .core_link_out(core_link_out),
        .link_out     (link_out)
    );

    // edge detection on synchronized pin levels
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            ld_prev   <= 1'b1;
        end else begin
            sclk_prev <= sclk_s;
            ld_prev   <= ld_s;
        end
    end

    assign test_on   = pad_s & rom_s;
    assign clk_rise  = sclk_s & ~sclk_prev;
    assign ld_fall   = ~ld_s & ld_prev;
    assign load_fire = test_on & ld_fall & ~sclk_s & (st_q != ST_LOAD);

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_ADDR;
            addr_q <= '0;
            data_q <= '0;
            cnt_q  <= '0;
        end else begin
            st_q   <= st_d;
            addr_q <= addr_d;
            data_q <= data_d;
            cnt_q  <= cnt_d;
        end
    end

    // transitions and register updates
    always_comb begin
        st_d   = st_q;
        addr_d = addr_q;
        data_d = data_q;
        cnt_d  = cnt_q;
        if (test_on) begin
            unique case (st_q)
                ST_ADDR: begin
                    if (load_fire) begin
                        st_d   = ST_LOAD;          // load-capture
                        data_d = rom_word;
                    end else if (clk_rise) begin
                        addr_d = {sdi_s, addr_q[ADDR_W-1:1]};
                    end
                end
                ST_LOAD: begin
                    if (ld_s) begin
                        st_d  = ST_DATA;           // strobe-release
                        cnt_d = '0;
                    end
                end
                ST_DATA: begin
                    if (load_fire) begin
                        st_d   = ST_LOAD;          // load-capture (reload)
                        data_d = rom_word;
                    end else if (clk_rise) begin
                        data_d = data_q >> 1;
                        if (cnt_q == LAST) begin
                            st_d  = ST_ADDR;       // word-done
                            cnt_d = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                default: st_d = ST_ADDR;
            endcase
        end
    end

    // output process
    always_comb begin
        test_sdo = data_q[0];
    end

    p_loop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pad_test_en |-> (link_out == ~link_in));

    p_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !test_on |=> ($stable(data_q) && $stable(addr_q) && $stable(st_q)));

    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_fire |=> (data_q == $past(rom_word) && st_q == ST_LOAD));

    p_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_fall && sclk_s && !clk_rise) |=> $stable(data_q));

    p_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (test_on && st_q == ST_DATA && clk_rise) |=> (data_q == ($past(data_q) >> 1)));

    p_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (test_on && st_q == ST_DATA && clk_rise && cnt_q == LAST) |=> (st_q == ST_ADDR));

    p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(test_on && st_q == ST_ADDR && clk_rise) |=> $stable(addr_q));
endmodule

// File: tb/sim_rom_test_port.sv
`timescale 1ns/1ps
module sim_rom_test_port;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int NL = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pad_test_en = 1'b0, rom_test_en = 1'b0;
    logic          test_sclk = 1'b0, test_sdi = 1'b0, load_n = 1'b1;
    logic          test_sdo;
    logic [NL-1:0] link_in = '0, core_link_out = '0, link_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    rom_test_port #(.ADDR_W(AW), .DATA_W(DW), .LINKS(NL), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .pad_test_en(pad_test_en), .rom_test_en(rom_test_en),
        .test_sclk(test_sclk), .test_sdi(test_sdi), .load_n(load_n), .test_sdo(test_sdo),
        .link_in(link_in), .core_link_out(core_link_out), .link_out(link_out)
    );

    function automatic logic [DW-1:0] ref_word(input int a);
        logic [DW-1:0] w;
        int t;
        if (a == 0) w = '1;
        else if (a == (1 << AW) - 1) begin
            for (int i = 0; i < DW; i++) w[i] = 1'(i % 2);
        end else begin
            t = (a * 37 + 11) ^ (a << (DW / 2));
            w = t[DW-1:0];
        end
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic clk_pulse();
        test_sclk = 1'b1; settle();
        test_sclk = 1'b0; settle();
    endtask

    task automatic pulse_load();
        load_n = 1'b0; settle();
        load_n = 1'b1; settle();
    endtask

    task automatic shift_addr(input logic [AW-1:0] a);
        for (int i = 0; i < AW; i++) begin
            test_sdi = a[i];
            clk_pulse();
        end
    endtask

    task automatic read_word(output logic [DW-1:0] w);
        w[0] = test_sdo;
        for (int i = 1; i < DW; i++) begin
            clk_pulse();
            w[i] = test_sdo;
        end
        clk_pulse();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] w, e;
        logic [DW-1:0] held;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();

        // R9 reset state
        check(test_sdo == 1'b0, "R9 sdo after reset", test_sdo, 0);
        core_link_out = 4'h5; #1;
        check(link_out == 4'h5, "R1 normal mode after reset", link_out, 5);

        // R1 loopback sweep in both pad modes
        for (int v = 0; v < 16; v++) begin
            link_in = 4'(v); core_link_out = 4'(v ^ 9); #1;
            check(link_out == core_link_out, "R1 pad off", link_out, core_link_out);
        end
        pad_test_en = 1'b1;
        for (int v = 0; v < 16; v++) begin
            link_in = 4'(v); #1;
            check(link_out == ~4'(v), "R1 pad on", link_out, ~4'(v));
        end

        rom_test_en = 1'b1;
        settle();

        // R3 R4 R6 R8 exhaustive readout
        for (int a = 0; a < (1 << AW); a++) begin
            e = ref_word(a);
            shift_addr(AW'(a));
            pulse_load();
            check(test_sdo == e[0], "R4 bit0 after load", test_sdo, e[0]);
            read_word(w);
            check(w == e, "R3/R6/R8 word readout", w, e);
        end
        check(test_sdo == 1'b0, "R6 zero fill after word", test_sdo, 0);

        // R7 reload from ADDR without shifting (address still all ones)
        e = ref_word((1 << AW) - 1);
        pulse_load();
        read_word(w);
        check(w == e, "R7 reload same word", w, e);

        // R7 reload in the middle of a read
        e = ref_word(5);
        shift_addr(AW'(5));
        pulse_load();
        clk_pulse(); clk_pulse(); clk_pulse();
        check(test_sdo == e[3], "R6 mid-read bit3", test_sdo, e[3]);
        pulse_load();
        check(test_sdo == e[0], "R7 mid-read reload bit0", test_sdo, e[0]);
        read_word(w);
        check(w == e, "R7 mid-read reload word", w, e);

        // R5 strobe while shift clock high is ignored
        for (int i = 0; i < AW - 1; i++) begin
            test_sdi = 1'b0;
            clk_pulse();
        end
        test_sdi = 1'b0;
        test_sclk = 1'b1; settle();
        load_n = 1'b0; settle();
        load_n = 1'b1; settle();
        test_sclk = 1'b0; settle();
        check(test_sdo == 1'b0, "R5 load with sclk high ignored", test_sdo, 0);
        e = ref_word(0);
        pulse_load();
        check(test_sdo == e[0], "R4 load address 0 bit0", test_sdo, e[0]);
        read_word(w);
        check(w == e, "R8 address 0 word", w, e);

        // R2 freeze with either enable low, then resume
        e = ref_word(6);
        shift_addr(AW'(6));
        pulse_load();
        clk_pulse(); clk_pulse();
        held = e;
        rom_test_en = 1'b0; settle();
        test_sdi = 1'b1;
        clk_pulse(); clk_pulse(); clk_pulse();
        pulse_load();
        check(test_sdo == held[2], "R2 hold with rom enable low", test_sdo, held[2]);
        rom_test_en = 1'b1; pad_test_en = 1'b0; settle();
        clk_pulse(); clk_pulse();
        pulse_load();
        check(test_sdo == held[2], "R2 hold with pad enable low", test_sdo, held[2]);
        pad_test_en = 1'b1; settle();
        w = '0;
        w[2] = test_sdo;
        for (int i = 3; i < DW; i++) begin
            clk_pulse();
            w[i] = test_sdo;
        end
        clk_pulse();
        check(w[DW-1:2] == e[DW-1:2], "R2 resume after freeze", w[DW-1:2], e[DW-1:2]);
        pulse_load();
        read_word(w);
        check(w == e, "R7 address held through freeze", w, e);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule